// File: doc/BRIEF.md
# Asynchronous Serial Port with Read-Then-Clear Status

This block is a single-channel asynchronous serial transmitter and receiver behind a small byte-wide register file. Six registers are provided: mode, bit rate, control, transmit data, status and receive data. Frames are one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A built-in rate generator divides the module clock by a 2-bit prescale selection and by an 8-bit divisor. One bit lasts 32 sub-ticks.

Software works through the status flags. To send, it writes the transmit data register, reads status and then writes a 0 to the empty flag. To receive, it reads the data and then clears the full flag the same way. A status flag falls only when software writes a 0 to it after having seen it as 1, so a clear cannot discard an event that arrived after the read. Three level interrupts are provided: receive error, receive full and transmit empty.

Top module: `serial_port`

## Requirements
- R1: After reset, status reads 0x84 (the empty flag in bit 7 and the transmit-end flag in bit 2 are set, all others are 0), `txd_o` is high, and all three interrupts are low.
- R2: The register addresses are 0 mode, 1 bit rate, 2 control, 3 transmit data, 4 status and 5 receive data. Mode holds the prescale in bits 1:0, parity enable in bit 5 and odd parity in bit 4, and reads back those bits with 0 elsewhere. Bit rate reads back all 8 bits. Control bit 7 enables the transmit interrupt, bit 6 enables the receive interrupts, bit 5 enables the transmitter and bit 4 enables the receiver.
- R3: Status bits 7 (transmit empty), 6 (receive full), 5 (overrun), 4 (framing error) and 3 (parity error) are cleared by writing 0 to that bit. The clear takes effect only if a status read has returned the bit as 1 since it last rose. Writing 1 has no effect. Bit 2 cannot be written.
- R4: One bit lasts 32×(N+1)×P module clocks, where N is the bit-rate value and P is 1, 4, 16 or 64 for prescale 0, 1, 2 or 3.
- R5: Once the empty flag is cleared with the transmitter enabled, the byte moves to the shifter and the empty flag sets again. The line then carries a low start bit, eight data bits least significant bit first, a parity bit when enabled (even unless odd is selected) and a high stop bit. The line is high while idle.
- R6: With the transmitter disabled, a pending byte is not sent, the line stays high and the empty flag stays 0.
- R7: The transmit-end flag sets when a stop bit finishes while the empty flag is 1. It clears when the empty flag is cleared.
- R8: With the receiver enabled, a complete frame loads the receive data register and sets the full flag. A parity mismatch also sets the parity-error flag, and a low stop bit also sets the framing-error flag.
- R9: A low level on the receive line that is gone at the 16th sub-tick after the falling edge is rejected as a false start.
- R10: A frame that completes while the full flag is 1 sets the overrun flag and is discarded. No further frame is received until the overrun flag is cleared.
- R11: `txi_o` = control bit 7 AND empty flag. `rxi_o` = control bit 6 AND full flag. `eri_o` = control bit 6 AND (overrun OR framing error OR parity error).
- R12: With the receiver disabled, frames on the line are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (marks status flags as seen) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| eri_o | output | 1 | Receive error interrupt |
| rxi_o | output | 1 | Receive full interrupt |
| txi_o | output | 1 | Transmit empty interrupt |

## Verification
The bench first clears status with writes while no flag has been seen, and then with writes of all ones. A design that ignored the seen rule, or that treated any write as a clear, would drop the transmit-empty flag at that point. The bench measures the start-bit width at two prescale and divisor settings, which exposes an off-by-one in the divisor or a wrong prescale table. The bench also runs an overrun and then clears only the full flag. A receiver that resumed before the overrun flag was cleared would then load the next byte. Finally, a short low glitch must not produce a byte, and a frame with a bad parity bit or a low stop bit must raise exactly the matching error flag.

// File: rtl/serial_pkg.sv
package serial_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DW     = 8;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_BRR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_TDR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_RDR  = 3'd5;

  // status bit positions (software clear values depend on these)
  localparam int unsigned B_TDRE = 7;
  localparam int unsigned B_RDRF = 6;
  localparam int unsigned B_ORER = 5;
  localparam int unsigned B_FER  = 4;
  localparam int unsigned B_PER  = 3;
  localparam int unsigned B_TEND = 2;
  localparam int unsigned B_LOW  = B_PER;

  // control bits as stored (wdata[7:4])
  localparam int unsigned C_TIE = 3;
  localparam int unsigned C_RIE = 2;
  localparam int unsigned C_TE  = 1;
  localparam int unsigned C_RE  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_START, ST_DATA, ST_PAR, ST_STOP
  } ser_state_e;
endpackage

// File: rtl/serial_baud_gen.sv
module serial_baud_gen #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       presc_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sub_tick_o
);
  logic [PRE_W-1:0] pre_cnt_q, pre_lim;
  logic [DIV_W-1:0] div_cnt_q;
  logic             pre_tick;

  always_comb begin
    unique case (presc_i)
      2'd0:    pre_lim = PRE_W'(0);
      2'd1:    pre_lim = PRE_W'(3);
      2'd2:    pre_lim = PRE_W'(15);
      default: pre_lim = PRE_W'(63);
    endcase
  end

  // >= keeps the counters bounded when settings shrink on the fly
  assign pre_tick   = (pre_cnt_q >= pre_lim);
  assign sub_tick_o = pre_tick && (div_cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '0;
      div_cnt_q <= '0;
    end else begin
      pre_cnt_q <= pre_tick ? '0 : pre_cnt_q + 1'b1;
      if (pre_tick) div_cnt_q <= (div_cnt_q >= div_i) ? '0 : div_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx import serial_pkg::*; #(
  parameter int unsigned SUBS = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sub_tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          txd_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int unsigned CNT_W = $clog2(SUBS);
  localparam int unsigned IDX_W = $clog2(DW);

  ser_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    sh_q;
  logic             par_q, pen_q, done_q;
  logic             bit_end;

  assign bit_end = sub_tick_i && (cnt_q == CNT_W'(SUBS-1));
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else begin
        if (sub_tick_i && state_q != ST_IDLE && state_q != ST_WAIT)
          cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
        unique case (state_q)
          ST_IDLE: if (load_i) begin
            sh_q    <= data_i;
            par_q   <= (^data_i) ^ par_odd_i;
            pen_q   <= par_en_i;
            state_q <= ST_WAIT;
          end
          // align the start bit to a sub-tick so every bit is full length
          ST_WAIT: if (sub_tick_i) begin
            cnt_q   <= '0;
            state_q <= ST_START;
          end
          ST_START: if (bit_end) begin
            idx_q   <= '0;
            state_q <= ST_DATA;
          end
          ST_DATA: if (bit_end) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(DW-1)) state_q <= pen_q ? ST_PAR : ST_STOP;
          end
          ST_PAR: if (bit_end) state_q <= ST_STOP;
          ST_STOP: if (bit_end) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx.sv
module serial_rx import serial_pkg::*; #(
  parameter int unsigned SUBS = 32,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sub_tick_i,
  input  logic          rxd_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          fer_o,
  output logic          per_o
);
  localparam int unsigned CNT_W = $clog2(SUBS);
  localparam int unsigned IDX_W = $clog2(DW);
  localparam int unsigned HALF  = SUBS / 2;

  logic [SYNC-1:0]  sync_q;
  logic             line, prev_q;
  ser_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    sh_q, data_q;
  logic             par_q, done_q, fer_q, per_q;
  logic             bit_end;

  assign line    = sync_q[SYNC-1];
  assign bit_end = sub_tick_i && (cnt_q == CNT_W'(SUBS-1));
  assign done_o  = done_q;
  assign data_o  = data_q;
  assign fer_o   = fer_q;
  assign per_o   = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], rxd_i};
      prev_q <= line;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      fer_q   <= 1'b0;
      per_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (prev_q && !line) begin
            cnt_q   <= '0;
            state_q <= ST_START;
          end
          ST_START: if (sub_tick_i) begin
            if (cnt_q == CNT_W'(HALF-1)) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= line ? ST_IDLE : ST_DATA;  // false start check
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: if (sub_tick_i) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (bit_end) begin
              sh_q  <= {line, sh_q[DW-1:1]};
              idx_q <= idx_q + 1'b1;
              if (idx_q == IDX_W'(DW-1)) state_q <= par_en_i ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR: if (sub_tick_i) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (bit_end) begin
              par_q   <= line;
              state_q <= ST_STOP;
            end
          end
          ST_STOP: if (sub_tick_i) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (bit_end) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              data_q  <= sh_q;
              fer_q   <= !line;
              per_q   <= par_en_i && (par_q ^ (^sh_q) ^ par_odd_i);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_port.sv
module serial_port import serial_pkg::*; #(
  parameter int unsigned DIV_W        = 8,
  parameter int unsigned SUBS_PER_BIT = 32,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              eri_o,
  output logic              rxi_o,
  output logic              txi_o
);
  localparam int unsigned PRE_W = 6;

  logic [1:0]       presc_q;
  logic             par_en_q, par_odd_q;
  logic [DIV_W-1:0] brr_q;
  logic [3:0]       ctrl_q;
  logic [DW-1:0]    tdr_q, rdr_q;
  logic             tend_q;

  logic             sub_tick;
  logic             tx_load, tx_busy, tx_done;
  logic             rx_en, rx_done, rx_fer, rx_per;
  logic [DW-1:0]    rx_data;

  logic [DW-1:B_LOW] set_vec, clr_vec, flags, seen;
  logic             wr_stat, rd_stat;
  logic             tdre_q, rdrf_q, orer_q, fer_q, per_q, rie;

  assign wr_stat = wr_i && (addr_i == A_STAT);
  assign rd_stat = rd_i && (addr_i == A_STAT);
  assign tdre_q  = flags[B_TDRE];
  assign rdrf_q  = flags[B_RDRF];
  assign orer_q  = flags[B_ORER];
  assign fer_q   = flags[B_FER];
  assign per_q   = flags[B_PER];
  assign rie     = ctrl_q[C_RIE];

  serial_baud_gen #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_baud (
    .clk_i, .rst_ni,
    .presc_i    (presc_q),
    .div_i      (brr_q),
    .sub_tick_o (sub_tick)
  );

  assign tx_load = ctrl_q[C_TE] && !tdre_q && !tx_busy;

  serial_tx #(.SUBS(SUBS_PER_BIT)) u_tx (
    .clk_i, .rst_ni,
    .en_i       (ctrl_q[C_TE]),
    .sub_tick_i (sub_tick),
    .load_i     (tx_load),
    .data_i     (tdr_q),
    .par_en_i   (par_en_q),
    .par_odd_i  (par_odd_q),
    .txd_o      (txd_o),
    .busy_o     (tx_busy),
    .done_o     (tx_done)
  );

  assign rx_en = ctrl_q[C_RE] && !orer_q;  // overrun holds reception

  serial_rx #(.SUBS(SUBS_PER_BIT), .SYNC(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni,
    .en_i       (rx_en),
    .sub_tick_i (sub_tick),
    .rxd_i      (rxd_i),
    .par_en_i   (par_en_q),
    .par_odd_i  (par_odd_q),
    .done_o     (rx_done),
    .data_o     (rx_data),
    .fer_o      (rx_fer),
    .per_o      (rx_per)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_TDRE] = tx_load;
    set_vec[B_RDRF] = rx_done && !rdrf_q;
    set_vec[B_ORER] = rx_done && rdrf_q;
    set_vec[B_FER]  = rx_done && !rdrf_q && rx_fer;
    set_vec[B_PER]  = rx_done && !rdrf_q && rx_per;
  end

  // one flag cell per status bit: set wins, clear needs a prior read of 1
  for (genvar i = B_LOW; i < DW; i++) begin : g_flag
    logic f_q, s_q;
    assign clr_vec[i] = wr_stat && !wdata_i[i] && s_q;
    assign flags[i]   = f_q;
    assign seen[i]    = s_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        f_q <= (i == B_TDRE);
        s_q <= 1'b0;
      end else if (set_vec[i]) begin
        f_q <= 1'b1;
        if (!f_q) s_q <= 1'b0;
      end else if (clr_vec[i]) begin
        f_q <= 1'b0;
        s_q <= 1'b0;
      end else if (rd_stat && f_q) begin
        s_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tend_q <= 1'b1;
    end else if (clr_vec[B_TDRE]) begin
      tend_q <= 1'b0;
    end else if (tx_done && tdre_q) begin
      tend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q   <= '0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      brr_q     <= '1;
      ctrl_q    <= '0;
      tdr_q     <= '1;
      rdr_q     <= '0;
    end else begin
      if (wr_i) begin
        unique case (addr_i)
          A_MODE: begin
            presc_q   <= wdata_i[1:0];
            par_en_q  <= wdata_i[5];
            par_odd_q <= wdata_i[4];
          end
          A_BRR:   brr_q  <= wdata_i;
          A_CTRL:  ctrl_q <= wdata_i[7:4];
          A_TDR:   tdr_q  <= wdata_i;
          default: ;
        endcase
      end
      if (set_vec[B_RDRF]) rdr_q <= rx_data;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = {2'b00, par_en_q, par_odd_q, 2'b00, presc_q};
      A_BRR:   rdata_o = brr_q;
      A_CTRL:  rdata_o = {ctrl_q, 4'b0000};
      A_TDR:   rdata_o = tdr_q;
      A_STAT:  rdata_o = {flags, tend_q, 2'b00};
      A_RDR:   rdata_o = rdr_q;
      default: rdata_o = '0;
    endcase
  end

  assign txi_o = ctrl_q[C_TIE] && tdre_q;
  assign rxi_o = rie && rdrf_q;
  assign eri_o = rie && (orer_q || fer_q || per_q);
endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk import serial_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              tdre,
  input logic              tend,
  input logic              rdrf,
  input logic              orer,
  input logic              rx_done,
  input logic              tx_busy,
  input logic              txd_o,
  input logic              eri_o,
  input logic              rie
);
  p_tdre_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdre && !(wr_i && addr_i == A_STAT) |=> tdre);

  p_rdrf_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdrf) |-> $past(rx_done));

  p_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orer |-> !rx_done);

  p_idle_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);

  p_tend_needs_tdre_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tend |-> tdre);

  p_eri_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eri_o |-> rie);
endmodule

bind serial_port serial_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .tdre    (tdre_q),
  .tend    (tend_q),
  .rdrf    (rdrf_q),
  .orer    (orer_q),
  .rx_done (rx_done),
  .tx_busy (tx_busy),
  .txd_o   (txd_o),
  .eri_o   (eri_o),
  .rie     (rie)
);

// File: tb/sim_serial_port.sv
module sim_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_MODE = 3'd0, A_BRR = 3'd1, A_CTRL = 3'd2,
                         A_TDR = 3'd3, A_STAT = 3'd4, A_RDR = 3'd5;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, rxd = 1'b1;
  logic [7:0] wdata = '0, rdata;
  logic       txd, eri, rxi, txi;

  int n_cmp = 0, n_bad = 0, bit_clks = 32;
  logic [9:0] sb_q[$];
  bit finished = 1'b0;

  serial_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd),
    .eri_o(eri), .rxi_o(rxi), .txi_o(txi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    reg_rd(a, v);
    check(tag, v, exp);
  endtask

  function automatic logic par_of(input logic [7:0] d, input int pm);
    return (^d) ^ (pm == 2);
  endfunction

  // driver: queue the frame the line must carry, then release it
  task automatic tx_send(input logic [7:0] d, input int pm);
    logic [7:0] v;
    reg_wr(A_TDR, d);
    reg_rd(A_STAT, v);
    sb_q.push_back({pm != 0, par_of(d, pm), d});
    reg_wr(A_STAT, 8'h78);
  endtask

  task automatic wait_tend();
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(A_STAT, v);
      if (v[2]) break;
    end
  endtask

  task automatic rx_frame(input logic [7:0] d, input int pm, input bit bad_par, input bit bad_stop);
    @(negedge clk); rxd = 1'b0;
    repeat (32) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (32) @(negedge clk);
    end
    if (pm != 0) begin
      rxd = par_of(d, pm) ^ bad_par;
      repeat (32) @(negedge clk);
    end
    rxd = !bad_stop;
    repeat (32) @(negedge clk);
    rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // monitor: decode the line and compare against the scoreboard
  initial begin
    logic [7:0] d;
    logic p, s;
    logic [9:0] exp, got;
    wait (rst_ni);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        if (sb_q.size() == 0) exp = 10'h3ff;
        else exp = sb_q.pop_front();
        repeat (bit_clks/2) @(negedge clk);
        check("R5 start bit", txd, 1'b0);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_clks) @(negedge clk);
          d[i] = txd;
        end
        p = 1'b0;
        if (exp[9]) begin
          repeat (bit_clks) @(negedge clk);
          p = txd;
        end
        repeat (bit_clks) @(negedge clk);
        s = txd;
        got = {exp[9], p, d};
        check("R5 frame", got, exp);
        check("R5 stop bit", s, 1'b1);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int w;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R3: clear attempt before any read must not take
    reg_wr(A_STAT, 8'h00);
    expect_reg("R1 R3 status after reset / unseen clear", A_STAT, 8'h84);
    check("R1 txd idle", txd, 1'b1);
    check("R1 irqs", {eri, rxi, txi}, 3'b000);
    reg_wr(A_STAT, 8'hFF);
    expect_reg("R3 write ones no effect", A_STAT, 8'h84);

    // R2 register readback
    reg_wr(A_MODE, 8'hF1);
    expect_reg("R2 mode readback", A_MODE, 8'h31);
    reg_wr(A_BRR, 8'h5A);
    expect_reg("R2 brr readback", A_BRR, 8'h5A);
    reg_wr(A_MODE, 8'h00);
    reg_wr(A_BRR, 8'h00);

    // R6: transmitter disabled keeps the byte pending
    reg_wr(A_CTRL, 8'h00);
    reg_wr(A_TDR, 8'h3C);
    reg_rd(A_STAT, v);
    reg_wr(A_STAT, 8'h78);
    expect_reg("R3 R7 seen clear drops TDRE and TEND", A_STAT, 8'h00);
    w = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) w++;
    end
    check("R6 line high with TE off", w, 0);
    expect_reg("R6 TDRE stays 0", A_STAT, 8'h00);
    sb_q.push_back({1'b0, 1'b0, 8'h3C});
    reg_wr(A_CTRL, 8'h20);
    repeat (2) @(negedge clk);
    expect_reg("R5 TDRE sets on transfer", A_STAT, 8'h80);
    wait_tend();
    expect_reg("R7 TEND after stop", A_STAT, 8'h84);

    // R11 transmit interrupt
    reg_wr(A_CTRL, 8'hA0);
    check("R11 txi", {eri, rxi, txi}, 3'b001);

    tx_send(8'h55, 0);
    expect_reg("R5 R7 after clear", A_STAT, 8'h80);
    wait_tend();
    reg_wr(A_MODE, 8'h20);
    tx_send(8'hA5, 1);
    wait_tend();
    reg_wr(A_MODE, 8'h30);
    tx_send(8'h96, 2);
    wait_tend();

    // R4 bit period at two settings
    reg_wr(A_CTRL, 8'h20);
    reg_wr(A_MODE, 8'h01);
    reg_wr(A_BRR, 8'h01);
    bit_clks = 256;
    tx_send(8'hFF, 0);
    w = 0;
    do @(negedge clk); while (txd !== 1'b0);
    while (txd === 1'b0) begin w++; @(negedge clk); end
    check("R4 start width /4 N=1", w, 256);
    wait_tend();
    reg_wr(A_MODE, 8'h02);
    reg_wr(A_BRR, 8'h00);
    bit_clks = 512;
    tx_send(8'hFF, 0);
    w = 0;
    do @(negedge clk); while (txd !== 1'b0);
    while (txd === 1'b0) begin w++; @(negedge clk); end
    check("R4 start width /16 N=0", w, 512);
    wait_tend();
    reg_wr(A_MODE, 8'h00);
    bit_clks = 32;

    // R8 receive
    reg_wr(A_CTRL, 8'h70);
    rx_frame(8'hC3, 0, 0, 0);
    expect_reg("R8 RDRF set", A_STAT, 8'hC4);
    check("R11 rxi without error", {eri, rxi}, 2'b01);
    expect_reg("R8 rx data", A_RDR, 8'hC3);
    reg_wr(A_STAT, 8'hBC);
    expect_reg("R3 RDRF cleared", A_STAT, 8'h84);

    reg_wr(A_MODE, 8'h20);
    rx_frame(8'h5A, 1, 0, 0);
    expect_reg("R8 good even parity", A_STAT, 8'hC4);
    reg_wr(A_STAT, 8'hBC);
    rx_frame(8'h5A, 1, 1, 0);
    expect_reg("R8 parity error", A_STAT, 8'hCC);
    check("R11 eri on PER", eri, 1'b1);
    reg_wr(A_STAT, 8'hB4);
    expect_reg("R3 PER and RDRF cleared", A_STAT, 8'h84);
    reg_wr(A_MODE, 8'h30);
    rx_frame(8'h11, 2, 0, 0);
    expect_reg("R8 good odd parity", A_STAT, 8'hC4);
    reg_wr(A_STAT, 8'hBC);

    reg_wr(A_MODE, 8'h00);
    rx_frame(8'h7E, 0, 0, 1);
    expect_reg("R8 framing error", A_STAT, 8'hD4);
    reg_wr(A_STAT, 8'hAC);
    expect_reg("R3 FER cleared", A_STAT, 8'h84);

    // R10 overrun
    rx_frame(8'h01, 0, 0, 0);
    rx_frame(8'h02, 0, 0, 0);
    expect_reg("R10 ORER set", A_STAT, 8'hE4);
    expect_reg("R10 byte discarded", A_RDR, 8'h01);
    check("R10 R11 eri on ORER", eri, 1'b1);
    reg_wr(A_STAT, 8'hBC);
    expect_reg("R10 RDRF only cleared", A_STAT, 8'hA4);
    rx_frame(8'h03, 0, 0, 0);
    expect_reg("R10 held while ORER", A_STAT, 8'hA4);
    expect_reg("R10 held data", A_RDR, 8'h01);
    reg_wr(A_STAT, 8'hDC);
    expect_reg("R10 ORER cleared", A_STAT, 8'h84);
    rx_frame(8'h04, 0, 0, 0);
    expect_reg("R10 resumes", A_RDR, 8'h04);
    reg_rd(A_STAT, v);
    reg_wr(A_STAT, 8'hBC);

    // R9 false start
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (100) @(negedge clk);
    expect_reg("R9 glitch rejected", A_STAT, 8'h84);
    rx_frame(8'h66, 0, 0, 0);
    expect_reg("R9 recovers", A_RDR, 8'h66);
    reg_rd(A_STAT, v);
    reg_wr(A_STAT, 8'hBC);

    // R12 receiver disabled
    reg_wr(A_CTRL, 8'h20);
    rx_frame(8'h99, 0, 0, 0);
    expect_reg("R12 frame ignored", A_STAT, 8'h84);
    expect_reg("R12 data kept", A_RDR, 8'h66);

    repeat (50) @(negedge clk);
    check("R5 all frames seen", sb_q.size(), 0);
    finish_run();
  end
endmodule